// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

A register-mapped controller for a port of up to eight general-purpose pins. Every pin owns a 32-byte window that holds its configuration, a read-only view of its synchronized input level, a float control, the level it drives and a write-one-to-clear register for its latched event. Software sets each pin as input or output. A pin drives its pad only when it is enabled, set as an output and not floated.

Each pin can raise an interrupt on a high level, a low level, a rising edge, a falling edge or either edge. Edge events are latched until software clears them. Level events follow the pin. One port-wide status word gathers the pending state of all pins. A single interrupt line is raised when any enabled pin has a pending event and its interrupt enable set. The bus is a plain address / write strobe / write data / read data interface. Reads are combinational and writes take effect on the clock edge.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset every configuration, float, output-value and latched-event bit is zero, so all pin output enables are low, the status word reads 0 and irq is low.
- R2: The configuration register at window offset 0x00 stores pin enable in bit 0, output direction in bit 1, trigger type in bits 3:2, polarity in bit 4 and interrupt enable in bit 6. Bits 5 and 7 and above read back as 0.
- R3: pin_oe[i] is high only when enable (bit 0) and direction (bit 1) are set and float (offset 0x0C bit 0) is clear. pin_out[i] follows bit 0 of the output value register at offset 0x10.
- R4: Bit 0 of the input register at offset 0x08 reports pin_in[i] through a two-stage synchronizer: a change is visible two rising clock edges after it is applied, and not after one.
- R5: Trigger type 1 is level: the pin is pending while its synchronized level equals the polarity bit (1 = high, 0 = low). The pending state is not latched.
- R6: Trigger type 2 is single edge: polarity 1 latches on a rising edge, polarity 0 on a falling edge, and the opposite edge latches nothing.
- R7: Trigger type 3 latches on either edge, whatever the polarity bit holds.
- R8: An edge event latches even while the interrupt enable (bit 6) or the pin enable is clear. irq is the OR over pins of pending AND interrupt enable AND pin enable.
- R9: Writing a value with bit 0 = 1 to offset 0x14 clears that pin's latched edge event. Writing bit 0 = 0 has no effect.
- R10: When a new edge event and a clear write for the same pin fall in the same cycle, the latched event stays set.
- R11: The status register at address 0x104 reports pin i's pending state (latched edge OR level condition) in bit i.
- R12: Trigger type 0 never makes a pin pending, whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (9) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS (8) | Pad input levels, asynchronous |
| pin_out | output | NUM_PINS (8) | Level to drive on each pad |
| pin_oe | output | NUM_PINS (8) | Output enable for each pad |
| irq | output | 1 | Port interrupt |

## Verification
The hardest case to reach from the ports is a new edge that is recognized in the same cycle as a software clear. The event appears only after the synchronizer and the edge register, so it lands exactly three edges after the pin change. The stimulus changes the pin on a falling clock edge, counts two rising edges, and then places the clear write so that it commits on the third. Random phases hold each pin pattern long enough to settle. They mix random trigger modes, polarities, enables and clear masks, and compare the status word and irq with a model that works per step from the old and new pin levels.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int WIN_W      = 5;        // 32-byte window per pin
    localparam int STATUS_OFS = 'h104;    // port pending-status word

    localparam logic [WIN_W-1:0] OFS_CFG  = 5'h00;
    localparam logic [WIN_W-1:0] OFS_IN   = 5'h08;
    localparam logic [WIN_W-1:0] OFS_OCTL = 5'h0C;
    localparam logic [WIN_W-1:0] OFS_OVAL = 5'h10;
    localparam logic [WIN_W-1:0] OFS_CLR  = 5'h14;

    localparam int CFG_EN  = 0;
    localparam int CFG_DIR = 1;
    localparam int CFG_TT  = 2;           // two bits: 3:2
    localparam int CFG_POL = 4;
    localparam int CFG_IE  = 6;
    localparam int CFG_USED_W = 7;

    typedef enum logic [1:0] {
        TRIG_OFF   = 2'd0,
        TRIG_LEVEL = 2'd1,
        TRIG_EDGE  = 2'd2,
        TRIG_BOTH  = 2'd3
    } trig_e;

    typedef struct packed {
        logic  ie;
        logic  pol;
        trig_e ttype;
        logic  dir;
        logic  en;
    } pin_cfg_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_port_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_cfg,
    input  logic                  wr_octl,
    input  logic                  wr_oval,
    input  logic                  wr_clr,
    input  logic [CFG_USED_W-1:0] wbits,
    input  logic                  sync_in,
    output pin_cfg_t              cfg,
    output logic                  floated,
    output logic                  out_val,
    output logic                  latched,
    output logic                  pending,
    output logic                  drive_en
);
    typedef struct packed {
        pin_cfg_t cfg;
        logic     flt;
        logic     oval;
        logic     prev;
        logic     latch;
    } cell_t;

    cell_t st_d, st_q;
    logic  rise, fall, evt, lvl_hit;

    always_comb begin
        st_d = st_q;
        if (wr_cfg) begin
            st_d.cfg.en    = wbits[CFG_EN];
            st_d.cfg.dir   = wbits[CFG_DIR];
            st_d.cfg.ttype = trig_e'(wbits[CFG_TT+1:CFG_TT]);
            st_d.cfg.pol   = wbits[CFG_POL];
            st_d.cfg.ie    = wbits[CFG_IE];
        end
        if (wr_octl) st_d.flt  = wbits[0];
        if (wr_oval) st_d.oval = wbits[0];

        rise = sync_in & ~st_q.prev;
        fall = ~sync_in & st_q.prev;
        unique case (st_q.cfg.ttype)
            TRIG_EDGE: evt = st_q.cfg.pol ? rise : fall;
            TRIG_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
        lvl_hit = (st_q.cfg.ttype == TRIG_LEVEL) && (sync_in == st_q.cfg.pol);

        st_d.prev  = sync_in;
        // a fresh event wins over a clear in the same cycle
        st_d.latch = (st_q.latch & ~(wr_clr & wbits[0])) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg      = st_q.cfg;
    assign floated  = st_q.flt;
    assign out_val  = st_q.oval;
    assign latched  = st_q.latch;
    assign pending  = st_q.latch | lvl_hit;
    assign drive_en = st_q.cfg.en & st_q.cfg.dir & ~st_q.flt;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int PIDX_W  = ADDR_W - WIN_W;
    localparam int WIN_END = NUM_PINS << WIN_W;

    logic [NUM_PINS-1:0] sync_vec, pend_vec, latch_vec, flt_vec, gate_vec;
    pin_cfg_t            cfg_arr [NUM_PINS];
    logic                in_win;
    logic [PIDX_W-1:0]   pin_idx;
    logic [WIN_W-1:0]    ofs;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CFG_USED_W];
    assign in_win  = int'(bus_addr) < WIN_END;
    assign pin_idx = bus_addr[ADDR_W-1:WIN_W];
    assign ofs     = bus_addr[WIN_W-1:0];

    gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_vec)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic sel;
        assign sel = bus_wr && in_win && (pin_idx == PIDX_W'(g));

        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cfg   (sel && ofs == OFS_CFG),
            .wr_octl  (sel && ofs == OFS_OCTL),
            .wr_oval  (sel && ofs == OFS_OVAL),
            .wr_clr   (sel && ofs == OFS_CLR),
            .wbits    (bus_wdata[CFG_USED_W-1:0]),
            .sync_in  (sync_vec[g]),
            .cfg      (cfg_arr[g]),
            .floated  (flt_vec[g]),
            .out_val  (pin_out[g]),
            .latched  (latch_vec[g]),
            .pending  (pend_vec[g]),
            .drive_en (pin_oe[g])
        );
        assign gate_vec[g] = pend_vec[g] & cfg_arr[g].ie & cfg_arr[g].en;
    end

    assign irq = |gate_vec;

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (pin_idx == PIDX_W'(p)) begin
                    unique case (ofs)
                        OFS_CFG:  bus_rdata = DATA_W'({cfg_arr[p].ie, 1'b0, cfg_arr[p].pol,
                                                       cfg_arr[p].ttype, cfg_arr[p].dir,
                                                       cfg_arr[p].en});
                        OFS_IN:   bus_rdata = DATA_W'(sync_vec[p]);
                        OFS_OCTL: bus_rdata = DATA_W'(flt_vec[p]);
                        OFS_OVAL: bus_rdata = DATA_W'(pin_out[p]);
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end else if (int'(bus_addr) == STATUS_OFS) begin
            bus_rdata = DATA_W'(pend_vec);
        end
    end
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk #(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                wbit0,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] sync_vec,
    input logic [NUM_PINS-1:0] pend_vec,
    input logic [NUM_PINS-1:0] latch_vec,
    input logic [NUM_PINS-1:0] flt_vec
);
    logic [1:0] up_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    // R4: input view is the pin level from two edges earlier
    p_input_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |-> (sync_vec == $past(pin_in, 2)));

    // R11: the port line needs some pending pin
    p_irq_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_vec != '0));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        logic clr_hit;
        assign clr_hit = bus_wr && wbit0 && (bus_addr == ADDR_W'(g * 32 + 'h14));

        // R9: a latched event survives until a clear write
        p_latch_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_vec[g] && !clr_hit) |=> latch_vec[g]);

        // R3: a floated pin never drives
        p_float_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
            flt_vec[g] |-> !pin_oe[g]);
    end
endmodule

bind gpio_port_irq gpio_port_irq_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wbit0     (bus_wdata[0]),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .sync_vec  (sync_vec),
    .pend_vec  (pend_vec),
    .latch_vec (latch_vec),
    .flt_vec   (flt_vec)
);

// File: tb/gpio_port_irq_tb.sv
`timescale 1ns/1ps
module gpio_port_irq_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpio_port_irq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [8:0] pa(int pin, int ofs);
        return 9'(pin * 32 + ofs);
    endfunction

    // edge event from requirements R6/R7
    function automatic logic edge_evt(logic [1:0] tt, logic pol, logic o, logic n);
        if (tt == 2'd2) return pol ? (!o && n) : (o && !n);
        if (tt == 2'd3) return o != n;
        return 1'b0;
    endfunction

    function automatic logic lvl_hit(logic [1:0] tt, logic pol, logic n);
        return (tt == 2'd1) && (n == pol);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(int p, logic v);
        @(negedge clk);
        pin_in[p] = v;
        settle();
    endtask

    logic [31:0] rv;

    // watchdog
    initial begin
        #500us;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();

        // R1 reset state
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(9'h104, rv); chk("R1 status", rv, 0);
        for (int p = 0; p < N; p++) begin
            rd(pa(p, 'h00), rv); chk("R1 cfg", rv, 0);
            rd(pa(p, 'h0C), rv); chk("R1 float", rv, 0);
            rd(pa(p, 'h10), rv); chk("R1 oval", rv, 0);
        end

        // R2 field positions and readback
        wr(pa(3, 'h00), 32'h0000_005F);
        rd(pa(3, 'h00), rv); chk("R2 cfg all fields", rv, 32'h5F);
        wr(pa(3, 'h00), 32'hFFFF_FFFF);
        rd(pa(3, 'h00), rv); chk("R2 reserved bits read 0", rv, 32'h5F);
        wr(pa(3, 'h00), 32'h0000_0014);
        rd(pa(3, 'h00), rv); chk("R2 type/pol only", rv, 32'h14);
        wr(pa(3, 'h00), 0);

        // R3 drive gating
        wr(pa(2, 'h10), 1);
        wr(pa(2, 'h00), 32'h3);
        #1 chk("R3 drives", 32'(pin_oe[2]), 1);
        chk("R3 out level", 32'(pin_out[2]), 1);
        wr(pa(2, 'h0C), 1);
        #1 chk("R3 floated", 32'(pin_oe[2]), 0);
        wr(pa(2, 'h0C), 0);
        wr(pa(2, 'h00), 32'h1);
        #1 chk("R3 input dir", 32'(pin_oe[2]), 0);
        wr(pa(2, 'h00), 32'h2);
        #1 chk("R3 disabled", 32'(pin_oe[2]), 0);
        wr(pa(2, 'h10), 0);
        #1 chk("R3 out low", 32'(pin_out[2]), 0);
        wr(pa(2, 'h00), 0);

        // R4 two-stage input
        @(negedge clk); pin_in[1] = 1'b1;
        @(posedge clk); #1 rd(pa(1, 'h08), rv); chk("R4 one edge", rv, 0);
        @(posedge clk); #1 rd(pa(1, 'h08), rv); chk("R4 two edges", rv, 1);
        set_pin(1, 1'b0);
        rd(pa(1, 'h08), rv); chk("R4 low", rv, 0);

        // R5 level high with irq
        wr(pa(0, 'h00), 32'h55);
        set_pin(0, 1'b1);
        rd(9'h104, rv); chk("R5 level high pending", rv, 32'h01);
        chk("R8 irq level", 32'(irq), 1);
        set_pin(0, 1'b0);
        rd(9'h104, rv); chk("R5 not latched", rv, 0);
        chk("R5 irq drop", 32'(irq), 0);
        wr(pa(0, 'h00), 32'h45);
        #1 rd(9'h104, rv); chk("R5 level low pending", rv, 32'h01);
        wr(pa(0, 'h00), 0);

        // R12 no trigger
        wr(pa(6, 'h00), 32'h41);
        set_pin(6, 1'b1); set_pin(6, 1'b0);
        rd(9'h104, rv); chk("R12 type 0 idle", rv, 0);
        wr(pa(6, 'h00), 0);

        // R6 rising, R8 latch without ie
        wr(pa(4, 'h00), 32'h19);
        set_pin(4, 1'b1);
        rd(9'h104, rv); chk("R6 rise latched", rv, 32'h10);
        chk("R8 no irq without ie", 32'(irq), 0);
        wr(pa(4, 'h00), 32'h58);
        #1 chk("R8 no irq pin disabled", 32'(irq), 0);
        wr(pa(4, 'h00), 32'h59);
        #1 chk("R8 irq with ie", 32'(irq), 1);
        wr(pa(4, 'h14), 0);
        rd(9'h104, rv); chk("R9 zero write ignored", rv, 32'h10);
        wr(pa(4, 'h14), 1);
        rd(9'h104, rv); chk("R9 clear", rv, 0);
        chk("R9 irq cleared", 32'(irq), 0);
        set_pin(4, 1'b0);
        rd(9'h104, rv); chk("R6 fall ignored in rising", rv, 0);
        wr(pa(4, 'h00), 32'h09);
        set_pin(4, 1'b1);
        rd(9'h104, rv); chk("R6 rise ignored in falling", rv, 0);
        set_pin(4, 1'b0);
        rd(9'h104, rv); chk("R6 fall latched", rv, 32'h10);
        wr(pa(4, 'h14), 1);
        wr(pa(4, 'h00), 0);

        // R7 both edges, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            wr(pa(7, 'h00), pol ? 32'h1D : 32'h0D);
            set_pin(7, 1'b1);
            rd(9'h104, rv); chk("R7 rise", rv, 32'h80);
            wr(pa(7, 'h14), 1);
            set_pin(7, 1'b0);
            rd(9'h104, rv); chk("R7 fall", rv, 32'h80);
            wr(pa(7, 'h14), 1);
        end
        wr(pa(7, 'h00), 0);

        // R10 clear and new edge in one cycle
        wr(pa(5, 'h00), 32'h19);
        @(negedge clk); pin_in[5] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(pa(5, 'h14), 1);
        settle();
        rd(9'h104, rv); chk("R10 edge beats clear", rv, 32'h20);
        wr(pa(5, 'h14), 1);
        rd(9'h104, rv); chk("R10 later clear", rv, 0);
        set_pin(5, 1'b0);
        wr(pa(5, 'h00), 0);

        // random phase: R11 status word and irq
        begin
            logic [1:0] tt [N];
            logic pol [N], en [N], ie [N];
            logic [N-1:0] lat, old, nw, clr, expst;
            logic expirq;
            void'($urandom(32'h5eed));
            lat = '0;
            old = pin_in;
            for (int it = 0; it < 160; it++) begin
                if (it % 8 == 0) begin
                    for (int p = 0; p < N; p++) begin
                        tt[p] = 2'($urandom_range(0, 3));
                        pol[p] = 1'($urandom_range(0, 1));
                        en[p] = 1'($urandom_range(0, 1));
                        ie[p] = 1'($urandom_range(0, 1));
                        wr(pa(p, 'h00), {25'd0, ie[p], 1'b0, pol[p], tt[p], 1'b0, en[p]});
                    end
                end
                nw = N'($urandom);
                if (it % 5 == 0) nw = old;
                @(negedge clk); pin_in = nw;
                settle();
                for (int p = 0; p < N; p++)
                    if (edge_evt(tt[p], pol[p], old[p], nw[p])) lat[p] = 1'b1;
                old = nw;
                clr = N'($urandom);
                for (int p = 0; p < N; p++)
                    if (clr[p]) begin
                        wr(pa(p, 'h14), 1);
                        lat[p] = 1'b0;
                    end
                expirq = 1'b0;
                for (int p = 0; p < N; p++) begin
                    expst[p] = lat[p] | lvl_hit(tt[p], pol[p], nw[p]);
                    if (expst[p] && en[p] && ie[p]) expirq = 1'b1;
                end
                #1 rd(9'h104, rv); chk("R11 status", rv, 32'(expst));
                chk("R8 irq OR", 32'(irq), 32'(expirq));
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule